// File: doc/BRIEF.md
# Pipelined Burst SRAM Address Front-End

This block is a synchronous burst memory with a small register-array store. Two active-low address strobes can open an access: one for a processor and one for a controller. The strobe that is recognized loads the external address into an address register. The same strobe seeds a 2-bit burst counter from the two lowest address bits. An active-low advance input then steps the counter through the rest of a four-word group.

Reads are pipelined. The array is read one clock after the address is registered, and the word appears on the output with a valid pulse. Writes capture the input word into a data register on the access edge and commit it to the array on the following edge. The bidirectional bus is split into an input word, an output word and an output enable. A sleep input freezes all access while the stored words are kept.

Top module: `burst_sram_core`

## Requirements
- R1: After reset `rd_valid` is 0, and with `oe_n` low `dout` reads 0 and `dout_en` is 1.
- R2: A recognized strobe loads `addr` into the address register and `addr[1:0]` into the burst counter. That address is the one accessed on the strobe edge.
- R3: When both strobes are low and `ce_n` is low, only the processor strobe is acted on. A processor-started access is always a read, and `we_n` is disregarded on that edge, so the memory is not written.
- R4: The processor strobe is ignored while `ce_n` is high. No access starts, and the address register and burst counter keep their values.
- R5: With `ce_n` high, a low controller strobe starts an access even if the processor strobe is also low. That access writes when `we_n` is low and reads otherwise.
- R6: A low `adv_n` on an edge with no recognized strobe advances the counter by one in linear order, wrapping from 3 to 0. Address bits above bit 1 stay fixed. The new address is accessed, and `we_n` selects read or write.
- R7: `adv_n` has no effect until a strobe has opened a burst after reset.
- R8: A write stores `din` at the accessed address, and a later read of that address returns it.
- R9: Read data and `rd_valid` appear exactly one edge after the edge that registered the address, that is, on the second edge after the request was presented.
- R10: `dout_en` equals the inverse of `oe_n`. While `oe_n` is high, `dout` reads 0.
- R11: While `sleep` is high, strobes, advances and writes are ignored, no read completes, and stored words are preserved.
- R12: In a cycle that follows no read access, `rd_valid` is 0 and the registered output word holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low chip enable, gates the processor strobe |
| proc_stb_n | input | 1 | Active-low processor address strobe |
| ctrl_stb_n | input | 1 | Active-low controller address strobe |
| adv_n | input | 1 | Active-low burst advance |
| we_n | input | 1 | Active-low write enable, sampled with the address |
| oe_n | input | 1 | Active-low output enable |
| sleep | input | 1 | Active-high sleep, blocks access and keeps contents |
| addr | input | ADDR_W | External address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, 0 when output is disabled |
| dout_en | output | 1 | Output drive enable |
| rd_valid | output | 1 | Pulses when new read data is presented |

## Verification
The bench drives both strobes together with `we_n` low. A design that let the controller win would store the word and skip the read. The bench also offers a processor strobe with `ce_n` high between two steps of an open burst. A design that failed to gate that strobe would reload the counter to a new address, and the next advance would read the wrong word. Bursts are started at offsets 1 and 2 so that a counter without wraparound or with a moving upper field reads outside its group. Every read result is matched against the cycle it was expected in, so a missing or extra pipeline stage shows up at once. The bench then fires writes, strobes and advances during sleep and reads back the whole array. A design that let any of them through would return a corrupted word or emit an unexpected valid pulse.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PROC = 2'd1,
        SRC_CTRL = 2'd2
    } strobe_src_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } acc_kind_t;

    function automatic logic [BURST_W-1:0] burst_next(input logic [BURST_W-1:0] c);
        return c + {{(BURST_W-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/bsr_strobe_arb.sv
module bsr_strobe_arb
    import bsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ce_n,
    input  logic        proc_stb_n,
    input  logic        ctrl_stb_n,
    input  logic        sleep,
    output strobe_src_e src
);

    logic proc_ok;
    logic ctrl_ok;

    assign proc_ok = !proc_stb_n && !ce_n && !sleep;
    assign ctrl_ok = !ctrl_stb_n && !sleep;

    always_comb begin
        if (proc_ok)      src = SRC_PROC;
        else if (ctrl_ok) src = SRC_CTRL;
        else              src = SRC_NONE;
    end

    // R3: processor wins a tie when enabled
    p_prio_r3: assert property (@(posedge clk) disable iff (rst)
        (!proc_stb_n && !ctrl_stb_n && !ce_n && !sleep) |-> src == SRC_PROC);

    // R4: chip enable high blocks the processor strobe
    p_gate_r4: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> src != SRC_PROC);

    // R11: nothing starts during sleep
    p_sleep_r11: assert property (@(posedge clk) disable iff (rst)
        sleep |-> src == SRC_NONE);

endmodule

// File: rtl/bsr_burst_ctr.sv
module bsr_burst_ctr
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_src_e       src,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_take,
    output acc_kind_t         pend
);

    localparam int HI_W = ADDR_W - BURST_W;

    logic [HI_W-1:0]    hi_q, hi_d;
    logic [BURST_W-1:0] cnt_q, cnt_d;
    logic               active_q;
    logic               adv_go;
    acc_kind_t          kind;

    assign adv_go = (src == SRC_NONE) && !adv_n && active_q && !sleep;

    always_comb begin
        hi_d    = hi_q;
        cnt_d   = cnt_q;
        kind.rd = 1'b0;
        kind.wr = 1'b0;
        if (src != SRC_NONE) begin
            hi_d    = addr[ADDR_W-1:BURST_W];
            cnt_d   = addr[BURST_W-1:0];
            kind.rd = (src == SRC_PROC) || we_n;
            kind.wr = (src == SRC_CTRL) && !we_n;
        end else if (adv_go) begin
            cnt_d   = burst_next(cnt_q);
            kind.rd = we_n;
            kind.wr = !we_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q     <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            pend     <= '0;
        end else begin
            hi_q  <= hi_d;
            cnt_q <= cnt_d;
            pend  <= kind;
            if (src != SRC_NONE) active_q <= 1'b1;
        end
    end

    assign addr_q  = {hi_q, cnt_q};
    assign wr_take = kind.wr;

    // R6: advance steps the low field and freezes the upper field
    p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        adv_go |=> (cnt_q == burst_next($past(cnt_q))) && (hi_q == $past(hi_q)));

    // R2: a recognized strobe loads the presented address
    p_ld_r2: assert property (@(posedge clk) disable iff (rst)
        (src != SRC_NONE) |=> addr_q == $past(addr));

endmodule

// File: rtl/bsr_store.sv
module bsr_store
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_q,
    input  acc_kind_t         pend,
    input  logic              wr_take,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout_q,
    output logic              rd_valid
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] din_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            din_q    <= '0;
            dout_q   <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (wr_take) din_q <= din;
            rd_valid <= pend.rd;
            if (pend.rd) dout_q <= mem[addr_q];
        end
    end

    always_ff @(posedge clk) begin
        if (pend.wr) mem[addr_q] <= din_q;
    end

    // R12: output word holds when no read was pending
    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !pend.rd |=> $stable(dout_q) && !rd_valid);

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              proc_stb_n,
    input  logic              ctrl_stb_n,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              rd_valid
);

    strobe_src_e       src;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_take;
    acc_kind_t         pend;
    logic [DATA_W-1:0] dout_q;

    bsr_strobe_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .ce_n       (ce_n),
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .sleep      (sleep),
        .src        (src)
    );

    bsr_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .src     (src),
        .adv_n   (adv_n),
        .we_n    (we_n),
        .sleep   (sleep),
        .addr    (addr),
        .addr_q  (addr_q),
        .wr_take (wr_take),
        .pend    (pend)
    );

    bsr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .addr_q   (addr_q),
        .pend     (pend),
        .wr_take  (wr_take),
        .din      (din),
        .dout_q   (dout_q),
        .rd_valid (rd_valid)
    );

    assign dout_en = !oe_n;
    assign dout    = oe_n ? '0 : dout_q;

    // R9: a processor strobe yields read data two edges later
    p_lat_r9: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_PROC) |=> ##1 rd_valid);

endmodule

// File: tb/burst_sram_core_tb.sv
module burst_sram_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b0, proc_stb_n = 1'b1, ctrl_stb_n = 1'b1;
    logic        adv_n = 1'b1, we_n = 1'b1, oe_n = 1'b0, sleep = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        dout_en, rd_valid;

    burst_sram_core #(.ADDR_W(6), .DATA_W(16)) u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .proc_stb_n(proc_stb_n),
        .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n), .we_n(we_n), .oe_n(oe_n),
        .sleep(sleep), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .rd_valid(rd_valid)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [15:0] d;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [15:0] shadow [64];
    int          cyc = 0;
    int          checks = 0;
    int          bad = 0;
    bit          m_active = 0;
    int          m_hi = 0;
    int          m_cnt = 0;
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] pat(input int a);
        return 16'hA000 + 16'(a * 3);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one clock of stimulus, model updates expectations
    task automatic step(input logic p_n, input logic c_n, input logic ce, input logic adv,
                        input logic we, input logic slp, input int a, input logic [15:0] d,
                        input string tag);
        int  eff;
        bit  rd, wr, pr, cr;
        exp_t e;
        @(posedge clk);
        #2;
        proc_stb_n = p_n; ctrl_stb_n = c_n; ce_n = ce; adv_n = adv;
        we_n = we; sleep = slp; addr = 6'(a); din = d;
        rd = 0; wr = 0; eff = 0;
        pr = !slp && !p_n && !ce;
        cr = !slp && !pr && !c_n;
        if (pr || cr) begin
            m_hi = a >> 2; m_cnt = a & 3; m_active = 1; eff = a;
            rd = pr || we;
            wr = cr && !we;
        end else if (!slp && !adv && m_active) begin
            m_cnt = (m_cnt + 1) & 3;
            eff = m_hi * 4 + m_cnt;
            rd = we;
            wr = !we;
        end
        if (rd) begin
            e.d = shadow[eff]; e.cyc = cyc + 2; e.tag = tag;
            q.push_back(e);
        end
        if (wr) shadow[eff] = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, 1, 0, 1, 1, 0, 0, 16'h0, "idle");
    endtask

    // monitor: scoreboard compare on read results (R9 timing, R10 output gating)
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rd_valid) begin
                if (q.size() == 0) begin
                    checks++; bad++;
                    $display("FAIL R11/R12 unexpected read actual=%h expected=none", dout);
                end else begin
                    exp_t e;
                    logic [15:0] ev;
                    e = q.pop_front();
                    ev = oe_n ? 16'h0 : e.d;
                    chk(dout == ev && dout_en == !oe_n, {e.tag, " data"}, dout, ev);
                    chk(cyc == e.cyc, {e.tag, " R9 latency"}, 16'(cyc), 16'(e.cyc));
                end
            end else if (q.size() > 0 && q[0].cyc <= cyc) begin
                exp_t e;
                e = q.pop_front();
                chk(1'b0, {e.tag, " R9 missing read"}, 16'(cyc), 16'(e.cyc));
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1;
            bad++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) shadow[i] = 16'h0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk(rd_valid == 1'b0 && dout == 16'h0 && dout_en == 1'b1, "R1 reset", dout, 16'h0);

        // R7: advance before any strobe
        step(1, 1, 0, 0, 1, 0, 0, 16'h0, "R7");
        idle(2);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R7 advance ignored", {15'h0, rd_valid}, 16'h0);

        // R8/R6: fill every group by write bursts, odd groups start at offset 2
        for (int b = 0; b < 64; b += 4) begin
            int s;
            s = b + ((b >> 2) & 1) * 2;
            step(1, 0, 0, 1, 0, 0, s, pat(s), "R8");
            for (int k = 1; k < 4; k++) begin
                int e2;
                e2 = b + ((s + k) & 3);
                step(1, 1, 0, 0, 0, 0, 0, pat(e2), "R8");
            end
        end
        idle(2);

        // R2/R6: read bursts with wraparound
        step(1, 0, 0, 1, 1, 0, 5, 16'h0, "R2");
        for (int k = 0; k < 3; k++) step(1, 1, 0, 0, 1, 0, 0, 16'h0, "R6");
        step(0, 1, 0, 1, 1, 0, 14, 16'h0, "R2");
        for (int k = 0; k < 3; k++) step(1, 1, 0, 0, 1, 0, 0, 16'h0, "R6");
        idle(3);

        // R4: gated processor strobe mid-burst
        step(1, 0, 0, 1, 1, 0, 9, 16'h0, "R4");
        step(0, 1, 1, 1, 1, 0, 40, 16'h0, "R4");
        step(1, 1, 0, 0, 1, 0, 0, 16'h0, "R4");
        idle(3);

        // R3: both strobes with chip enable, write disregarded
        step(0, 0, 0, 1, 0, 0, 20, 16'hBEEF, "R3");
        idle(1);
        step(1, 0, 0, 1, 1, 0, 20, 16'h0, "R3");
        idle(3);

        // R5: both strobes with chip enable high, controller writes
        step(0, 0, 1, 1, 0, 0, 24, 16'h1234, "R5");
        step(1, 0, 0, 1, 1, 0, 24, 16'h0, "R5");
        idle(3);

        // R10: output disabled during a read
        oe_n = 1'b1;
        step(1, 0, 0, 1, 1, 0, 33, 16'h0, "R10");
        idle(3);
        @(negedge clk);
        chk(dout == 16'h0 && dout_en == 1'b0, "R10 disabled", dout, 16'h0);
        #2 oe_n = 1'b0;
        #1 chk(dout == shadow[33] && dout_en == 1'b1, "R10 re-enabled", dout, shadow[33]);

        // R11: activity during sleep
        step(1, 0, 0, 1, 0, 1, 0, 16'hDEAD, "R11");
        step(0, 1, 0, 1, 1, 1, 4, 16'h0, "R11");
        step(1, 1, 0, 0, 0, 1, 0, 16'hDEAD, "R11");
        step(1, 0, 0, 0, 0, 1, 37, 16'hDEAD, "R11");
        step(1, 1, 0, 1, 1, 1, 0, 16'h0, "R11");
        idle(2);
        for (int b = 0; b < 64; b += 4) begin
            step(1, 0, 0, 1, 1, 0, b, 16'h0, "R11");
            for (int k = 0; k < 3; k++) step(1, 1, 0, 0, 1, 0, 0, 16'h0, "R11");
        end
        idle(3);

        // R12: output holds after the last read
        step(1, 0, 0, 1, 1, 0, 50, 16'h0, "R12");
        idle(5);
        @(negedge clk);
        chk(dout == shadow[50] && rd_valid == 1'b0, "R12 hold", dout, shadow[50]);
        chk(q.size() == 0, "R9 pending reads drained", 16'(q.size()), 16'h0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule